// File: doc/BRIEF.md
# Padded Strided Tile Loader

This block carries out a single tile load. An external memory holds a large two-dimensional array. The block reads a rectangle of that array, row by row, where each row starts a fixed stride further on than the one before. It writes the result into one of four local scratchpads, and it surrounds the rectangle with a border of pad elements as it goes. The border positions never cause a memory read. Their value is made locally from a 2-bit pad code. Real elements are fetched over a request/response read port. The responses may be delayed by a variable number of cycles, but they return in the order the requests were made.

A job starts with a one-cycle `start` pulse. On that pulse the block samples the configuration ports: DRAM base, SRAM base, row count, row length, row stride, four border widths, pad code and target scratchpad. The complete padded tile is written in row-major order to consecutive scratchpad addresses, beginning at the SRAM base. When the last write has been made, `done` pulses. Two engines do the work:

- **Walker.** It visits every position of the padded tile and issues a read for each real position. Its states are `WK_IDLE`, `WK_WALK` and `WK_FLUSH`. It moves IDLE→WALK on an accepted start, WALK→FLUSH when the last position has been queued, and FLUSH→IDLE on the writer's completion pulse. A start whose padded tile is empty stays in IDLE and gives an immediate done.
- **Writer.** It drains an ordered slot queue so that a pad element can never get ahead of an earlier real element that is still in flight. Its states are `WR_IDLE` and `WR_RUN`. It moves IDLE→RUN on launch, and RUN→IDLE when it pops the slot marked last.

Top module: `tile_pad_loader`

## Requirements
- R1: A job writes exactly (pad_top + rows + pad_bottom) × (pad_left + cols + pad_right) elements. The writes go to consecutive scratchpad addresses starting at the SRAM base, one per cycle strobe, in row-major order of the padded tile.
- R2: Reads are issued only for real positions, which number rows × cols. The element at tile row r, column c is read from dram_base + r × stride + c, and its response data is written at that position. A request that is stalled by a low ready keeps its address.
- R3: A pad position is written with a value set by the pad code: 0 gives all zeros, 1 gives the most negative signed value (0x80 for 8-bit data), 2 gives the most positive signed value (0x7F), and 3 gives all zeros.
- R4: `sp_wr_en` is a 4-bit strobe with exactly one bit high per write. The bit index equals the target code: 0 micro-op, 1 weight, 2 input, 3 accumulator.
- R5: With variable response latency and a stalling read port, the written sequence is still the row-major sequence. A pad write never takes the place of an earlier real element whose data is still pending.
- R6: `done` is high for one cycle, in the cycle after the final write strobe. `busy` is high from the cycle after an accepted start through the done cycle, and low in the cycle after.
- R7: If rows or cols is zero, only pad values are written and no read is issued. If the whole padded tile is empty, no write occurs and `done` pulses in the cycle after `start`.
- R8: A `start` that arrives while `busy` is high is ignored. The running job completes exactly as configured.
- R9: After reset, `busy`, `done`, `rd_req_valid` and `sp_wr_en` are all low.
- R10: At most FIFO_DEPTH reads are in flight, counting both requests awaiting a response and responses awaiting their write. No internal queue overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job start; configuration is sampled with it |
| cfg_dram_base | input | ADDR_W | External element address of tile row 0, column 0 |
| cfg_sram_base | input | SRAM_W | First scratchpad address written |
| cfg_rows | input | LEN_W | Number of real rows |
| cfg_cols | input | LEN_W | Real elements per row |
| cfg_stride | input | LEN_W | Distance in elements between row starts |
| cfg_pad_top | input | PAD_W | Pad rows before the real rows |
| cfg_pad_bottom | input | PAD_W | Pad rows after the real rows |
| cfg_pad_left | input | PAD_W | Pad columns before the real columns |
| cfg_pad_right | input | PAD_W | Pad columns after the real columns |
| cfg_pad_code | input | 2 | Pad value select |
| cfg_mem_sel | input | 2 | Target scratchpad code |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job completion pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read element address |
| rd_rsp_valid | input | 1 | Read data valid (in request order) |
| rd_rsp_data | input | DATA_W | Read data |
| sp_wr_en | output | 4 | One-hot scratchpad write strobe |
| sp_wr_addr | output | SRAM_W | Scratchpad write address |
| sp_wr_data | output | DATA_W | Scratchpad write data |

## Verification
A position's write strobe appears one cycle after its slot leaves the queue. `done` follows the final strobe by exactly one cycle, and `busy` falls in the cycle after `done`. For an empty tile, `done` is due one cycle after `start`. The bench drives inputs and samples outputs on the falling edge and stamps every strobe and done pulse with a cycle index. From those stamps it checks the one-cycle gap between the last write and done, and the start-to-done gap for the empty case. The read model registers a request only when valid and ready are both high ahead of a rising edge. It returns data no earlier than the following cycle, so the expected data for each position is fixed however long a response takes.

// File: rtl/tile_ld_pkg.sv
`timescale 1ns/1ps
package tile_ld_pkg;
    localparam int NUM_MEMS = 4;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_WALK  = 2'd1,
        WK_FLUSH = 2'd2
    } walk_state_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_RUN  = 1'b1
    } write_state_e;

    typedef enum logic [1:0] {
        PADV_ZERO = 2'd0,
        PADV_MIN  = 2'd1,
        PADV_MAX  = 2'd2,
        PADV_RSVD = 2'd3
    } pad_code_e;

    // one queued tile position, in write order
    typedef struct packed {
        logic is_pad;
        logic last;
    } slot_t;
endpackage

// File: rtl/tl_fifo.sv
`timescale 1ns/1ps
module tl_fifo #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    fill;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            fill <= fill + CW'(push) - CW'(pop);
        end
    end

    assign dout  = store[rd_ptr];
    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/tl_walker.sv
`timescale 1ns/1ps
module tl_walker
    import tile_ld_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int PAD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] dram_base,
    input  logic [LEN_W-1:0]  rows,
    input  logic [LEN_W-1:0]  cols,
    input  logic [LEN_W-1:0]  stride,
    input  logic [PAD_W-1:0]  pad_top,
    input  logic [PAD_W-1:0]  pad_bottom,
    input  logic [PAD_W-1:0]  pad_left,
    input  logic [PAD_W-1:0]  pad_right,
    input  logic              job_done,
    input  logic              slot_full,
    input  logic              req_ready,
    output logic              launch,
    output logic              empty_done,
    output logic              busy,
    output logic              slot_push,
    output slot_t             slot_data,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int POS_W = LEN_W + 2;

    walk_state_e state_q, state_d;

    logic [LEN_W-1:0]  rows_q, cols_q, stride_q;
    logic [PAD_W-1:0]  pt_q, pb_q, pl_q, pr_q;
    logic [POS_W-1:0]  y_q, x_q;
    logic [ADDR_W-1:0] row_addr_q;
    logic              empty_done_q;

    logic [POS_W-1:0]  y_end_in, x_end_in;
    logic              zero_in;
    logic [POS_W-1:0]  y_lo, y_hi, x_lo, x_hi, y_end, x_end;
    logic              in_y, in_x, is_real, last_x, last_pos, advance;

    // geometry of the requested tile, from the ports
    always_comb begin
        y_end_in = POS_W'(pad_top) + POS_W'(rows) + POS_W'(pad_bottom);
        x_end_in = POS_W'(pad_left) + POS_W'(cols) + POS_W'(pad_right);
        zero_in  = (y_end_in == '0) || (x_end_in == '0);
        launch   = (state_q == WK_IDLE) && start && !zero_in;
    end

    // geometry of the running job
    always_comb begin
        y_lo     = POS_W'(pt_q);
        y_hi     = POS_W'(pt_q) + POS_W'(rows_q);
        x_lo     = POS_W'(pl_q);
        x_hi     = POS_W'(pl_q) + POS_W'(cols_q);
        y_end    = y_hi + POS_W'(pb_q);
        x_end    = x_hi + POS_W'(pr_q);
        in_y     = (y_q >= y_lo) && (y_q < y_hi);
        in_x     = (x_q >= x_lo) && (x_q < x_hi);
        is_real  = in_y && in_x;
        last_x   = (x_q == x_end - 1'b1);
        last_pos = last_x && (y_q == y_end - 1'b1);
        advance  = (state_q == WK_WALK) && !slot_full && (!is_real || req_ready);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WK_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE:  if (launch)              state_d = WK_WALK;
            WK_WALK:  if (advance && last_pos) state_d = WK_FLUSH;
            WK_FLUSH: if (job_done)            state_d = WK_IDLE;
            default:                           state_d = WK_IDLE;
        endcase
    end

    // job fields and position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q       <= '0;
            cols_q       <= '0;
            stride_q     <= '0;
            pt_q         <= '0;
            pb_q         <= '0;
            pl_q         <= '0;
            pr_q         <= '0;
            y_q          <= '0;
            x_q          <= '0;
            row_addr_q   <= '0;
            empty_done_q <= 1'b0;
        end else begin
            empty_done_q <= (state_q == WK_IDLE) && start && zero_in;
            if (launch) begin
                rows_q     <= rows;
                cols_q     <= cols;
                stride_q   <= stride;
                pt_q       <= pad_top;
                pb_q       <= pad_bottom;
                pl_q       <= pad_left;
                pr_q       <= pad_right;
                y_q        <= '0;
                x_q        <= '0;
                row_addr_q <= dram_base;
            end else if (advance) begin
                if (last_x) begin
                    x_q <= '0;
                    y_q <= y_q + 1'b1;
                    if (in_y) row_addr_q <= row_addr_q + ADDR_W'(stride_q);
                end else begin
                    x_q <= x_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy             = (state_q != WK_IDLE);
        empty_done       = empty_done_q;
        req_valid        = (state_q == WK_WALK) && is_real && !slot_full;
        req_addr         = row_addr_q + ADDR_W'(x_q - x_lo);
        slot_push        = advance;
        slot_data.is_pad = !is_real;
        slot_data.last   = last_pos;
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WK_IDLE) && start |=> $stable(rows_q) && $stable(cols_q) && $stable(stride_q));

    // R7
    pad_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WK_WALK) && ((rows_q == '0) || (cols_q == '0)) |-> !req_valid);
endmodule

// File: rtl/tl_writer.sv
`timescale 1ns/1ps
module tl_writer
    import tile_ld_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SRAM_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [SRAM_W-1:0]   sram_base,
    input  logic [1:0]          mem_sel,
    input  logic [1:0]          pad_code,
    input  logic                slot_empty,
    input  slot_t               slot_head,
    input  logic                dat_empty,
    input  logic [DATA_W-1:0]   dat_head,
    output logic                slot_pop,
    output logic                dat_pop,
    output logic [NUM_MEMS-1:0] sp_wr_en,
    output logic [SRAM_W-1:0]   sp_wr_addr,
    output logic [DATA_W-1:0]   sp_wr_data,
    output logic                job_done
);
    write_state_e state_q, state_d;

    logic [SRAM_W-1:0] ptr_q, addr_q;
    logic [DATA_W-1:0] data_q, pad_val;
    logic [1:0]        sel_q;
    pad_code_e         code_q;
    logic              wr_vld_q, last_wr_q, done_q, pop;

    always_comb begin
        unique case (code_q)
            PADV_MIN: pad_val = {1'b1, {(DATA_W-1){1'b0}}};
            PADV_MAX: pad_val = {1'b0, {(DATA_W-1){1'b1}}};
            default:  pad_val = '0;
        endcase
        pop = (state_q == WR_RUN) && !slot_empty && (slot_head.is_pad || !dat_empty);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (launch)                 state_d = WR_RUN;
            WR_RUN:  if (pop && slot_head.last)  state_d = WR_IDLE;
            default:                             state_d = WR_IDLE;
        endcase
    end

    // write port registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            sel_q     <= '0;
            code_q    <= PADV_ZERO;
            wr_vld_q  <= 1'b0;
            last_wr_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            wr_vld_q  <= pop;
            last_wr_q <= pop && slot_head.last;
            done_q    <= last_wr_q;
            if (launch) begin
                ptr_q  <= sram_base;
                sel_q  <= mem_sel;
                code_q <= pad_code_e'(pad_code);
            end else if (pop) begin
                ptr_q  <= ptr_q + 1'b1;
                addr_q <= ptr_q;
                data_q <= slot_head.is_pad ? pad_val : dat_head;
            end
        end
    end

    // outputs
    always_comb begin
        slot_pop   = pop;
        dat_pop    = pop && !slot_head.is_pad;
        sp_wr_addr = addr_q;
        sp_wr_data = data_q;
        job_done   = done_q;
    end

    for (genvar i = 0; i < NUM_MEMS; i++) begin : g_strobe
        assign sp_wr_en[i] = wr_vld_q && (sel_q == 2'(i));
    end

    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld_q && $past(wr_vld_q) |-> sp_wr_addr == $past(sp_wr_addr) + 1'b1);

    // R6
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(wr_vld_q) && !wr_vld_q);

    // R4
    sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld_q && $past(wr_vld_q) |-> sp_wr_en == $past(sp_wr_en));
endmodule

// File: rtl/tile_pad_loader.sv
`timescale 1ns/1ps
module tile_pad_loader
    import tile_ld_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 32,
    parameter int SRAM_W     = 16,
    parameter int LEN_W      = 16,
    parameter int PAD_W      = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   cfg_dram_base,
    input  logic [SRAM_W-1:0]   cfg_sram_base,
    input  logic [LEN_W-1:0]    cfg_rows,
    input  logic [LEN_W-1:0]    cfg_cols,
    input  logic [LEN_W-1:0]    cfg_stride,
    input  logic [PAD_W-1:0]    cfg_pad_top,
    input  logic [PAD_W-1:0]    cfg_pad_bottom,
    input  logic [PAD_W-1:0]    cfg_pad_left,
    input  logic [PAD_W-1:0]    cfg_pad_right,
    input  logic [1:0]          cfg_pad_code,
    input  logic [1:0]          cfg_mem_sel,
    output logic                busy,
    output logic                done,
    output logic                rd_req_valid,
    input  logic                rd_req_ready,
    output logic [ADDR_W-1:0]   rd_req_addr,
    input  logic                rd_rsp_valid,
    input  logic [DATA_W-1:0]   rd_rsp_data,
    output logic [NUM_MEMS-1:0] sp_wr_en,
    output logic [SRAM_W-1:0]   sp_wr_addr,
    output logic [DATA_W-1:0]   sp_wr_data
);
    localparam int SLOT_W = $bits(slot_t);

    logic              launch, empty_done, job_done;
    logic              slot_push, slot_pop, slot_empty, slot_full;
    slot_t             slot_in, slot_head;
    logic [SLOT_W-1:0] slot_head_raw;
    logic              dat_pop, dat_empty, dat_full;
    logic [DATA_W-1:0] dat_head;

    tl_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAD_W(PAD_W)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dram_base  (cfg_dram_base),
        .rows       (cfg_rows),
        .cols       (cfg_cols),
        .stride     (cfg_stride),
        .pad_top    (cfg_pad_top),
        .pad_bottom (cfg_pad_bottom),
        .pad_left   (cfg_pad_left),
        .pad_right  (cfg_pad_right),
        .job_done   (job_done),
        .slot_full  (slot_full),
        .req_ready  (rd_req_ready),
        .launch     (launch),
        .empty_done (empty_done),
        .busy       (busy),
        .slot_push  (slot_push),
        .slot_data  (slot_in),
        .req_valid  (rd_req_valid),
        .req_addr   (rd_req_addr)
    );

    tl_fifo #(.WIDTH(SLOT_W), .DEPTH(FIFO_DEPTH)) u_slot_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (slot_push),
        .din   (slot_in),
        .pop   (slot_pop),
        .dout  (slot_head_raw),
        .empty (slot_empty),
        .full  (slot_full)
    );
    assign slot_head = slot_t'(slot_head_raw);

    // every in-flight read owns a queued slot, so this queue cannot fill past it
    tl_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_data_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rd_rsp_valid),
        .din   (rd_rsp_data),
        .pop   (dat_pop),
        .dout  (dat_head),
        .empty (dat_empty),
        .full  (dat_full)
    );

    tl_writer #(.DATA_W(DATA_W), .SRAM_W(SRAM_W)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .sram_base  (cfg_sram_base),
        .mem_sel    (cfg_mem_sel),
        .pad_code   (cfg_pad_code),
        .slot_empty (slot_empty),
        .slot_head  (slot_head),
        .dat_empty  (dat_empty),
        .dat_head   (dat_head),
        .slot_pop   (slot_pop),
        .dat_pop    (dat_pop),
        .sp_wr_en   (sp_wr_en),
        .sp_wr_addr (sp_wr_addr),
        .sp_wr_data (sp_wr_data),
        .job_done   (job_done)
    );

    assign done = job_done | empty_done;

    // R10
    rsp_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_full |-> !rd_rsp_valid);
endmodule

// File: tb/tb_tile_pad_loader.sv
`timescale 1ns/1ps
module tb_tile_pad_loader;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_dram_base = '0;
    logic [15:0] cfg_sram_base = '0, cfg_rows = '0, cfg_cols = '0, cfg_stride = '0;
    logic [3:0]  cfg_pad_top = '0, cfg_pad_bottom = '0, cfg_pad_left = '0, cfg_pad_right = '0;
    logic [1:0]  cfg_pad_code = '0, cfg_mem_sel = '0;
    logic        busy, done, rd_req_valid, rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
    logic [31:0] rd_req_addr;
    logic [DW-1:0] rd_rsp_data = '0, sp_wr_data;
    logic [3:0]  sp_wr_en;
    logic [15:0] sp_wr_addr;

    always #2.5 clk = ~clk;

    tile_pad_loader dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_dram_base(cfg_dram_base), .cfg_sram_base(cfg_sram_base),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_stride(cfg_stride),
        .cfg_pad_top(cfg_pad_top), .cfg_pad_bottom(cfg_pad_bottom),
        .cfg_pad_left(cfg_pad_left), .cfg_pad_right(cfg_pad_right),
        .cfg_pad_code(cfg_pad_code), .cfg_mem_sel(cfg_mem_sel),
        .busy(busy), .done(done),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .sp_wr_en(sp_wr_en), .sp_wr_addr(sp_wr_addr), .sp_wr_data(sp_wr_data)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit stall_mode = 0, slow_mode = 0;
    logic [15:0] lf = 16'hACE1;

    // capture of one job
    int n_wr, n_rd, n_done, last_wr_cyc, done_cyc;
    logic [15:0] cap_addr [512];
    logic [DW-1:0] cap_data [512];
    logic [3:0] cap_en [512];
    logic [31:0] cap_rd [512];

    // in-order read model
    logic [31:0] q_addr [64];
    int q_due [64];
    int qh = 0, qt = 0, last_due = 0;

    function automatic logic [DW-1:0] memv(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd7 + 32'd3;
        return t[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] padv(input logic [1:0] code);
        case (code)
            2'd1:    return 8'h80;
            2'd2:    return 8'h7F;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            qh = 0; qt = 0; last_due = 0;
            rd_rsp_valid = 1'b0;
            rd_req_ready = 1'b0;
        end else begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rd_req_ready = stall_mode ? (lf[1:0] != 2'b00) : 1'b1;
            if (rd_req_valid && rd_req_ready) begin
                int due;
                due = cyc + (slow_mode ? 1 + int'(lf[6:4]) : 1);
                if (due < last_due) due = last_due;
                last_due = due;
                q_addr[qt % 64] = rd_req_addr;
                q_due[qt % 64] = due;
                qt++;
                if (n_rd < 512) cap_rd[n_rd] = rd_req_addr;
                n_rd++;
            end
            rd_rsp_valid = 1'b0;
            if (qh != qt && q_due[qh % 64] <= cyc) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data = memv(q_addr[qh % 64]);
                qh++;
            end
            if (sp_wr_en != 4'b0) begin
                if (n_wr < 512) begin
                    cap_addr[n_wr] = sp_wr_addr;
                    cap_data[n_wr] = sp_wr_data;
                    cap_en[n_wr] = sp_wr_en;
                end
                n_wr++;
                last_wr_cyc = cyc;
            end
            if (done) begin
                n_done++;
                done_cyc = cyc;
            end
        end
    end

    // runs one job and compares it against the expected tile
    task automatic run_job(input string jt, input logic [31:0] dram, input logic [15:0] sram,
                           input int rows, input int cols, input int stride,
                           input int pt, input int pb, input int pl, input int pr,
                           input logic [1:0] code, input logic [1:0] sel,
                           input bit stall, input bit slow, input bit poke);
        int ty, tx, idx, ri, guard, start_cyc;
        logic [DW-1:0] exp_d;
        bit real_pos;
        @(negedge clk);
        stall_mode = stall; slow_mode = slow;
        n_wr = 0; n_rd = 0; n_done = 0; last_wr_cyc = -1; done_cyc = -1;
        cfg_dram_base = dram; cfg_sram_base = sram;
        cfg_rows = 16'(rows); cfg_cols = 16'(cols); cfg_stride = 16'(stride);
        cfg_pad_top = 4'(pt); cfg_pad_bottom = 4'(pb); cfg_pad_left = 4'(pl); cfg_pad_right = 4'(pr);
        cfg_pad_code = code; cfg_mem_sel = sel;
        start = 1'b1; start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            // R8: a second start with other fields while busy
            chk(busy == 1'b1, "R8", "busy at second start", busy, 1);
            cfg_dram_base = 32'h9000; cfg_sram_base = 16'h0700; cfg_rows = 16'd1; cfg_cols = 16'd1;
            cfg_pad_top = 4'd0; cfg_pad_bottom = 4'd0; cfg_pad_left = 4'd0; cfg_pad_right = 4'd0;
            cfg_pad_code = 2'd2; cfg_mem_sel = 2'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (n_done == 0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);

        ty = pt + rows + pb;
        tx = pl + cols + pr;
        if (rows == 0 || cols == 0) begin
            ty = (rows == 0) ? pt + pb : ty;
            tx = (cols == 0) ? pl + pr : tx;
        end
        // R6 done exactly once, one cycle after the last write
        chk(n_done == 1, {jt, " R6"}, "done pulses", n_done, 1);
        if (ty * tx > 0)
            chk(done_cyc == last_wr_cyc + 1, {jt, " R6"}, "done cycle after last write",
                done_cyc, last_wr_cyc + 1);
        else
            chk(done_cyc == start_cyc + 1, {jt, " R7"}, "empty-job done cycle", done_cyc, start_cyc + 1);
        chk(busy == 1'b0, {jt, " R6"}, "busy after done", busy, 0);
        // R1 count
        chk(n_wr == ty * tx, {jt, " R1"}, "write count", n_wr, ty * tx);
        // R2 / R7 read count
        chk(n_rd == rows * cols, {jt, " R2 R7"}, "read count", n_rd, rows * cols);

        idx = 0; ri = 0;
        for (int y = 0; y < ty; y++) begin
            for (int x = 0; x < tx; x++) begin
                logic [31:0] ea;
                real_pos = (y >= pt) && (y < pt + rows) && (x >= pl) && (x < pl + cols);
                ea = dram + 32'((y - pt) * stride) + 32'(x - pl);
                exp_d = real_pos ? memv(ea) : padv(code);
                if (idx < n_wr && idx < 512) begin
                    chk(cap_addr[idx] == sram + 16'(idx), {jt, " R1"}, "write address",
                        cap_addr[idx], sram + 16'(idx));
                    chk(cap_en[idx] == (4'b1 << sel), {jt, " R4"}, "write strobe",
                        cap_en[idx], 4'b1 << sel);
                    chk(cap_data[idx] == exp_d, real_pos ? {jt, " R2 R5"} : {jt, " R3 R5"},
                        "write data", cap_data[idx], exp_d);
                end
                if (real_pos) begin
                    if (ri < n_rd && ri < 512)
                        chk(cap_rd[ri] == ea, {jt, " R2"}, "read address", cap_rd[ri], ea);
                    ri++;
                end
                idx++;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R9
        chk(busy == 1'b0, "R9", "busy in reset", busy, 0);
        chk(done == 1'b0, "R9", "done in reset", done, 0);
        chk(rd_req_valid == 1'b0, "R9", "read valid in reset", rd_req_valid, 0);
        chk(sp_wr_en == 4'b0, "R9", "strobe in reset", sp_wr_en, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && sp_wr_en == 4'b0, "R9", "idle after reset", busy, 0);
    endtask

    initial begin
        t_reset();
        // 4x4 from a 16-wide array, border of one, zero pad, input memory
        run_job("tile4x4",   32'h100, 16'h0020, 4, 4, 16, 1, 1, 1, 1, 2'd0, 2'd2, 0, 0, 0);
        run_job("stalled",   32'h100, 16'h0040, 4, 4, 16, 1, 1, 1, 1, 2'd1, 2'd0, 1, 1, 0);
        run_job("nopad",     32'h0F0, 16'h0000, 3, 5, 7, 0, 0, 0, 0, 2'd1, 2'd1, 1, 1, 0);
        run_job("asym",      32'h2000, 16'hFFFC, 2, 2, 20, 2, 0, 0, 3, 2'd2, 2'd3, 0, 1, 0);
        run_job("rows0 R7",  32'h300, 16'h0100, 0, 3, 8, 1, 1, 1, 1, 2'd2, 2'd2, 0, 0, 0);
        run_job("cols0 R7",  32'h300, 16'h0110, 2, 0, 8, 1, 1, 1, 0, 2'd3, 2'd1, 1, 0, 0);
        run_job("empty R7",  32'h300, 16'h0120, 0, 0, 8, 0, 0, 0, 0, 2'd0, 2'd0, 0, 0, 0);
        run_job("busy R8",   32'h500, 16'h0200, 4, 4, 16, 1, 1, 1, 1, 2'd1, 2'd1, 1, 1, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule